// File: doc/BRIEF.md
# Programmable Logic Cell with Lookup Table and Flip-Flop

This block is one cell of a programmable logic fabric. It holds a lookup table, a bit-level adder/subtractor and a single flip-flop. The lookup table evaluates any function of its data inputs from a truth-table mask. The adder computes a sum for each of two incoming carries, so a later stage can select between them without waiting. The flip-flop can register the cell's own combinational result. It can also capture a data input or the shift-chain input from the neighbouring cell. This lets a cell hold an unrelated register while its table serves other logic.

All configuration arrives on static input ports. These set the truth-table mask, the mode, the register source, the feedback option, the chain-head flag and the asynchronous-load value. The register controls come from signals shared across a group of cells: clock, asynchronous clear, asynchronous load, synchronous clear, synchronous load and clock enable. Cells are chained through the shift-chain pins, the lookup-table chain pin and the carry pins.

Top module: `lc_cell`

## Requirements
- R1: In normal mode (`cfg_arith`=0), `comb_out` equals bit `cfg_mask[{d_in[3],d_in[2],d_in[1],x}]`, where x is `d_in[0]` (least significant index bit). `lut_chain_out` always carries this table value, in both modes.
- R2: In arithmetic mode (`cfg_arith`=1), let A = `d_in[0]` and B = `d_in[1]` XOR `sub_en`. Then `comb_out` = A^B^c0 and `sum_alt` = A^B^c1. `cout0` and `cout1` are the majority of (A, B, c0) and of (A, B, c1), where c0/c1 are the effective carries.
- R3: With `cfg_first`=1, both effective carries equal `sub_en` and `cin0`/`cin1` have no effect. This makes a chain head compute A+B, or A-B in two's complement. With `cfg_first`=0, c0=`cin0` and c1=`cin1`.
- R4: In normal mode `sub_en` has no effect on `comb_out`, and `cout0`, `cout1` and `sum_alt` are 0.
- R5: On a rising `clk` with `ena`=1 and no clear, load or synchronous override, the register captures its source: `cfg_regsrc` 0 or 3 = `comb_out`, 1 = `d_in[3]`, 2 = `reg_chain_in`.
- R6: With `cfg_fb`=1, the register output replaces `d_in[0]` as the x index bit in normal mode and as A in arithmetic mode.
- R7: `aclr`=1 forces the register to 0 at once, regardless of the clock or any other control, and holds it there.
- R8: A rising `aload` with `aclr`=0 sets the register to `cfg_aload_val` at once. Each clock edge while `aload` is high keeps that value.
- R9: On a rising `clk` with `ena`=1, `sclr` clears the register. Otherwise `sload` loads `d_in[2]`. Both work in either mode, and `sclr` wins over `sload`.
- R10: With `ena`=0, clock edges leave the register unchanged; `sclr` and `sload` are then ignored.
- R11: `reg_out` and `reg_chain_out` both present the register's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| aclr | input | 1 | Asynchronous clear, active high |
| aload | input | 1 | Asynchronous load, acts on its rising edge |
| sclr | input | 1 | Synchronous clear |
| sload | input | 1 | Synchronous load of d_in[2] |
| ena | input | 1 | Clock enable |
| sub_en | input | 1 | 1 = subtract in arithmetic mode |
| d_in | input | N_IN | Data inputs |
| cin0 | input | 1 | First carry-in from previous cell |
| cin1 | input | 1 | Second carry-in from previous cell |
| reg_chain_in | input | 1 | Shift-chain input from previous cell |
| cfg_mask | input | 2**N_IN | Truth-table mask |
| cfg_arith | input | 1 | 1 = arithmetic mode |
| cfg_first | input | 1 | Cell is the chain head |
| cfg_fb | input | 1 | Register feedback into the table |
| cfg_regsrc | input | 2 | Register data source select |
| cfg_aload_val | input | 1 | Value for asynchronous load |
| comb_out | output | 1 | Unregistered cell result |
| sum_alt | output | 1 | Sum for the second carry |
| lut_chain_out | output | 1 | Table value to next cell |
| reg_out | output | 1 | Registered result |
| reg_chain_out | output | 1 | Shift-chain output to next cell |
| cout0 | output | 1 | Carry-out for first carry |
| cout1 | output | 1 | Carry-out for second carry |

## Verification
The bound assertions watch the register on every clock edge. They check that a clear shows at the output, that an enable-low edge holds the value, that synchronous clear and load take effect, and that shift-chain capture occurs. They also check that the carry-outs stay quiet in normal mode. The table lookup, the arithmetic for both carries, the chain-head carry forcing, the feedback substitution and the relative timing of the asynchronous clear and load need the bench. Its behavioural model covers these cases by comparing every output across many randomly drawn configurations and input streams.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [1:0] {
    SRC_COMB  = 2'd0,
    SRC_DATA  = 2'd1,
    SRC_CHAIN = 2'd2,
    SRC_COMB2 = 2'd3
  } reg_src_e;

  localparam int unsigned MIN_INPUTS = 3;
endpackage

// File: rtl/lc_lut.sv
module lc_lut #(
  parameter int unsigned N_IN = 4,
  localparam int unsigned MASK_W = 1 << N_IN
) (
  input  logic [MASK_W-1:0] mask,
  input  logic [N_IN-1:0]   sel,
  output logic              y
);
  for (genvar l = 0; l < N_IN; l++) begin : g_lvl
    localparam int unsigned W = MASK_W >> (l + 1);
    logic [W-1:0] node;
    for (genvar n = 0; n < W; n++) begin : g_n
      if (l == 0) begin : g_leaf
        assign node[n] = sel[0] ? mask[2*n+1] : mask[2*n];
      end else begin : g_inner
        assign node[n] = sel[l] ? g_lvl[l-1].node[2*n+1] : g_lvl[l-1].node[2*n];
      end
    end
  end

  assign y = g_lvl[N_IN-1].node[0];
endmodule

// File: rtl/lc_arith.sv
module lc_arith (
  input  logic en,
  input  logic first,
  input  logic sub_en,
  input  logic a,
  input  logic b_raw,
  input  logic cin0,
  input  logic cin1,
  output logic sum0,
  output logic sum1,
  output logic cout0,
  output logic cout1
);
  logic b_eff, c0, c1, s0, s1, k0, k1;

  always_comb begin
    b_eff = b_raw ^ sub_en;
    c0    = first ? sub_en : cin0;
    c1    = first ? sub_en : cin1;
    s0    = a ^ b_eff ^ c0;
    s1    = a ^ b_eff ^ c1;
    k0    = (a & b_eff) | (c0 & (a ^ b_eff));
    k1    = (a & b_eff) | (c1 & (a ^ b_eff));
  end

  assign sum0  = en & s0;
  assign sum1  = en & s1;
  assign cout0 = en & k0;
  assign cout1 = en & k1;
endmodule

// File: rtl/lc_ff.sv
module lc_ff (
  input  logic clk,
  input  logic aclr,
  input  logic aload,
  input  logic aload_val,
  input  logic ena,
  input  logic sclr,
  input  logic sload,
  input  logic sload_d,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or posedge aclr or posedge aload) begin
    if (aclr) begin
      q <= 1'b0;
    end else if (aload) begin
      q <= aload_val;
    end else if (ena) begin
      if (sclr) begin
        q <= 1'b0;
      end else if (sload) begin
        q <= sload_d;
      end else begin
        q <= d;
      end
    end
  end
endmodule

// File: rtl/lc_cell.sv
module lc_cell
  import lc_pkg::*;
#(
  parameter int unsigned N_IN = 4,
  localparam int unsigned MASK_W = 1 << N_IN
) (
  input  logic              clk,
  input  logic              aclr,
  input  logic              aload,
  input  logic              sclr,
  input  logic              sload,
  input  logic              ena,
  input  logic              sub_en,
  input  logic [N_IN-1:0]   d_in,
  input  logic              cin0,
  input  logic              cin1,
  input  logic              reg_chain_in,
  input  logic [MASK_W-1:0] cfg_mask,
  input  logic              cfg_arith,
  input  logic              cfg_first,
  input  logic              cfg_fb,
  input  logic [1:0]        cfg_regsrc,
  input  logic              cfg_aload_val,
  output logic              comb_out,
  output logic              sum_alt,
  output logic              lut_chain_out,
  output logic              reg_out,
  output logic              reg_chain_out,
  output logic              cout0,
  output logic              cout1
);
  logic            q;
  logic            x_bit;
  logic [N_IN-1:0] idx;
  logic            lut_y;
  logic            sum0;
  logic            ff_d;
  reg_src_e        src;

  assign x_bit = cfg_fb ? q : d_in[0];
  assign idx   = {d_in[N_IN-1:1], x_bit};

  lc_lut #(.N_IN(N_IN)) u_lut (
    .mask (cfg_mask),
    .sel  (idx),
    .y    (lut_y)
  );

  lc_arith u_arith (
    .en     (cfg_arith),
    .first  (cfg_first),
    .sub_en (sub_en),
    .a      (x_bit),
    .b_raw  (d_in[1]),
    .cin0   (cin0),
    .cin1   (cin1),
    .sum0   (sum0),
    .sum1   (sum_alt),
    .cout0  (cout0),
    .cout1  (cout1)
  );

  assign comb_out      = cfg_arith ? sum0 : lut_y;
  assign lut_chain_out = lut_y;
  assign src           = reg_src_e'(cfg_regsrc);

  always_comb begin
    unique case (src)
      SRC_DATA:  ff_d = d_in[N_IN-1];
      SRC_CHAIN: ff_d = reg_chain_in;
      default:   ff_d = comb_out;
    endcase
  end

  lc_ff u_ff (
    .clk       (clk),
    .aclr      (aclr),
    .aload     (aload),
    .aload_val (cfg_aload_val),
    .ena       (ena),
    .sclr      (sclr),
    .sload     (sload),
    .sload_d   (d_in[2]),
    .d         (ff_d),
    .q         (q)
  );

  assign reg_out       = q;
  assign reg_chain_out = q;
endmodule

// File: rtl/lc_cell_chk.sv
module lc_cell_chk #(
  parameter int unsigned N_IN = 4
) (
  input logic            clk,
  input logic            aclr,
  input logic            aload,
  input logic            sclr,
  input logic            sload,
  input logic            ena,
  input logic [N_IN-1:0] d_in,
  input logic            reg_chain_in,
  input logic            cfg_arith,
  input logic [1:0]      cfg_regsrc,
  input logic            reg_out,
  input logic            cout0,
  input logic            cout1,
  input logic            sum_alt
);
  // R7: clear is visible on the register output at every sampled edge
  p_aclr_r7: assert property (@(posedge clk) aclr |-> reg_out == 1'b0);

  // R10: enable low holds the value across an edge
  p_hold_r10: assert property (@(posedge clk) disable iff (aclr || aload)
    !ena |=> $stable(reg_out));

  // R9: synchronous clear
  p_sclr_r9: assert property (@(posedge clk) disable iff (aclr || aload)
    (ena && sclr) |=> reg_out == 1'b0);

  // R9: synchronous load of data input 2
  p_sload_r9: assert property (@(posedge clk) disable iff (aclr || aload)
    (ena && !sclr && sload) |=> reg_out == $past(d_in[2]));

  // R5: shift-chain capture
  p_chain_r5: assert property (@(posedge clk) disable iff (aclr || aload)
    (ena && !sclr && !sload && cfg_regsrc == 2'd2) |=> reg_out == $past(reg_chain_in));

  // R4: arithmetic outputs quiet in normal mode
  p_quiet_r4: assert property (@(posedge clk)
    !cfg_arith |-> (cout0 == 1'b0 && cout1 == 1'b0 && sum_alt == 1'b0));
endmodule

bind lc_cell lc_cell_chk #(.N_IN(N_IN)) u_chk (
  .clk          (clk),
  .aclr         (aclr),
  .aload        (aload),
  .sclr         (sclr),
  .sload        (sload),
  .ena          (ena),
  .d_in         (d_in),
  .reg_chain_in (reg_chain_in),
  .cfg_arith    (cfg_arith),
  .cfg_regsrc   (cfg_regsrc),
  .reg_out      (reg_out),
  .cout0        (cout0),
  .cout1        (cout1),
  .sum_alt      (sum_alt)
);

// File: tb/tb_lc_cell.sv
`timescale 1ns/1ps
module tb_lc_cell;
  localparam int N_IN = 4;
  localparam int MASK_W = 1 << N_IN;
  localparam int N_CYC = 4000;

  logic clk = 1'b0;
  logic aclr, aload, sclr, sload, ena, sub_en, cin0, cin1, reg_chain_in;
  logic [N_IN-1:0] d_in;
  logic [MASK_W-1:0] cfg_mask;
  logic cfg_arith, cfg_first, cfg_fb, cfg_aload_val;
  logic [1:0] cfg_regsrc;
  logic comb_out, sum_alt, lut_chain_out, reg_out, reg_chain_out, cout0, cout1;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  int    mq;
  int    mq_next;
  bit    prev_aload;
  string q_tag;
  string nxt_tag;

  always #2 clk = ~clk;

  lc_cell #(.N_IN(N_IN)) dut (
    .clk(clk), .aclr(aclr), .aload(aload), .sclr(sclr), .sload(sload), .ena(ena),
    .sub_en(sub_en), .d_in(d_in), .cin0(cin0), .cin1(cin1), .reg_chain_in(reg_chain_in),
    .cfg_mask(cfg_mask), .cfg_arith(cfg_arith), .cfg_first(cfg_first), .cfg_fb(cfg_fb),
    .cfg_regsrc(cfg_regsrc), .cfg_aload_val(cfg_aload_val),
    .comb_out(comb_out), .sum_alt(sum_alt), .lut_chain_out(lut_chain_out),
    .reg_out(reg_out), .reg_chain_out(reg_chain_out), .cout0(cout0), .cout1(cout1)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_comb();
    int a, b, c0, c1, idx, lut, e_comb, e_alt, e_k0, e_k1, src;
    string t;
    a   = cfg_fb ? mq : int'(d_in[0]);
    idx = int'(d_in[3]) * 8 + int'(d_in[2]) * 4 + int'(d_in[1]) * 2 + a;
    lut = int'((cfg_mask >> idx) & 1);
    if (cfg_arith) begin
      b  = int'(d_in[1]) ^ int'(sub_en);
      c0 = cfg_first ? int'(sub_en) : int'(cin0);
      c1 = cfg_first ? int'(sub_en) : int'(cin1);
      e_comb = (a + b + c0) % 2;  e_k0 = (a + b + c0) / 2;
      e_alt  = (a + b + c1) % 2;  e_k1 = (a + b + c1) / 2;
      t = cfg_fb ? "R6" : (cfg_first ? "R3" : "R2");
    end else begin
      e_comb = lut; e_alt = 0; e_k0 = 0; e_k1 = 0;
      t = cfg_fb ? "R6" : "R1";
    end
    check(t, "comb_out", int'(comb_out), e_comb);
    check(cfg_fb ? "R6" : "R1", "lut_chain_out", int'(lut_chain_out), lut);
    check(cfg_arith ? t : "R4", "sum_alt", int'(sum_alt), e_alt);
    check(cfg_arith ? t : "R4", "cout0", int'(cout0), e_k0);
    check(cfg_arith ? t : "R4", "cout1", int'(cout1), e_k1);
    case (cfg_regsrc)
      2'd1:    src = int'(d_in[3]);
      2'd2:    src = int'(reg_chain_in);
      default: src = e_comb;
    endcase
    if (aclr) begin mq_next = 0; nxt_tag = "R7"; end
    else if (aload) begin mq_next = int'(cfg_aload_val); nxt_tag = "R8"; end
    else if (!ena) begin mq_next = mq; nxt_tag = "R10"; end
    else if (sclr) begin mq_next = 0; nxt_tag = "R9"; end
    else if (sload) begin mq_next = int'(d_in[2]); nxt_tag = "R9"; end
    else begin mq_next = src; nxt_tag = "R5"; end
  endtask

  task automatic check_q();
    check(q_tag, "reg_out", int'(reg_out), mq);
    check("R11", "reg_chain_out", int'(reg_chain_out), mq);
  endtask

  task automatic new_config(input int kind);
    cfg_mask      = MASK_W'($urandom);
    cfg_arith     = (kind % 2) == 1;
    cfg_first     = ($urandom % 3) == 0;
    cfg_fb        = ($urandom % 4) == 0;
    cfg_regsrc    = 2'($urandom);
    cfg_aload_val = 1'($urandom);
  endtask

  task automatic drive_random();
    aclr         = ($urandom % 40) == 0;
    aload        = ($urandom % 30) == 0;
    ena          = ($urandom % 4) != 0;
    sclr         = ($urandom % 10) == 0;
    sload        = ($urandom % 8) == 0;
    sub_en       = 1'($urandom);
    d_in         = N_IN'($urandom);
    cin0         = 1'($urandom);
    cin1         = 1'($urandom);
    reg_chain_in = 1'($urandom);
  endtask

  task automatic apply_async();
    if (aclr) begin mq = 0; q_tag = "R7"; end
    else if (aload && !prev_aload) begin mq = int'(cfg_aload_val); q_tag = "R8"; end
    prev_aload = aload;
  endtask

  // one cycle: check register, drive, check comb, clock
  task automatic cycle();
    @(negedge clk);
    check_q();
    apply_async();
    #1;
    check_q();
    check_comb();
    @(posedge clk);
    mq = mq_next;
    q_tag = nxt_tag;
  endtask

  initial begin
    aclr = 1'b1; aload = 1'b0; sclr = 1'b0; sload = 1'b0; ena = 1'b0;
    sub_en = 1'b0; d_in = '0; cin0 = 1'b0; cin1 = 1'b0; reg_chain_in = 1'b0;
    new_config(0);
    mq = 0; q_tag = "R7"; prev_aload = 1'b0;
    #1;
    check("R7", "reset reg_out", int'(reg_out), 0);
    @(posedge clk);
    // directed: chain-head subtraction 2-bit style, 1 - 1 = 0 borrow-free
    @(negedge clk);
    aclr = 1'b0; cfg_arith = 1'b1; cfg_first = 1'b1; cfg_fb = 1'b0;
    sub_en = 1'b1; d_in = 4'b0011; cin0 = 1'b0; cin1 = 1'b0; ena = 1'b0;
    #1;
    check("R3", "1-1 sum", int'(comb_out), 0);
    check("R3", "1-1 carry", int'(cout0), 1);
    d_in = 4'b0001; cin0 = 1'b0; cin1 = 1'b1; sub_en = 1'b0;
    #0.5;
    check("R3", "1+0 sum with cin ignored", int'(sum_alt), 1);
    cfg_arith = 1'b0;
    #0.5;
    check("R4", "normal mode cout0", int'(cout0), 0);
    @(posedge clk);
    for (int c = 0; c < N_CYC; c++) begin
      if (c % 40 == 0) begin
        @(negedge clk);
        new_config(c / 40);
        drive_random();
        aclr = 1'b0; aload = 1'b0;
        apply_async();
        #1;
        check_comb();
        @(posedge clk);
        mq = mq_next; q_tag = nxt_tag;
      end
      @(negedge clk);
      check_q();
      drive_random();
      apply_async();
      #1;
      check_q();
      check_comb();
      @(posedge clk);
      mq = mq_next;
      q_tag = nxt_tag;
    end
    @(negedge clk);
    aclr = 1'b0; aload = 1'b0; ena = 1'b0;
    apply_async();
    cycle();
    @(negedge clk);
    check_q();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule